// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multi-register transfer command into a series of memory beats. A command carries a base address, a 16-bit mask that selects registers, a two-bit addressing mode, a writeback enable, an element-size select and a load/store flag. The block counts the selected registers and works out the first address, the last address and the updated base for the chosen mode. It then issues one beat per selected register, lowest index first, and holds each beat on a request/ready handshake until memory accepts it.

After the final beat is accepted the block pulses `done`. In the same cycle it pulses the base write strobe with the new base value when writeback was requested, and raises a mismatch flag if the last address issued differs from the planned end. The decrement-after mode is not supported. A command in that mode is rejected with an error pulse and moves no data. The register file, the memory and condition evaluation sit outside this block.

Top module: `blk_xfer_addr_seq`

## Requirements
- R1: The number of beats equals the number of set bits in `cmd_list`, and every beat's `mem_load` equals the command's `cmd_load`.
- R2: Mode `cmd_mode`=2'b01 (increment-after) starts at base and ends at base + n*size - size. The writeback value is base + n*size.
- R3: Mode 2'b11 (increment-before) starts at base + size and ends at base + n*size. The writeback value equals that end address.
- R4: Mode 2'b10 (decrement-before) starts at base - n*size and ends at base - size. The writeback value equals that start address.
- R5: Beats visit the set bits of `cmd_list` from lowest index to highest, with `mem_reg` giving the bit index. Each beat's address is one element above the previous one, and the element size is 8 bytes when `cmd_dword`=1 and 4 bytes when it is 0. All address arithmetic wraps modulo 2^32.
- R6: `base_wr` pulses only in the `done` cycle, one cycle after the last beat is accepted, and only when `cmd_wb` was set. It then carries the writeback value on `base_val`.
- R7: `err_end` is sampled in the `done` cycle and is 1 only if the last address issued differs from the planned end address. On a correct plan it stays 0.
- R8: Mode 2'b00 (decrement-after) produces a one-cycle `err_unimpl` pulse in the cycle after acceptance. It produces no beat, no `done` and no `base_wr`.
- R9: An empty `cmd_list` produces `done` in the cycle after acceptance, with no beat and no `base_wr`.
- R10: A command is taken only while `cmd_ready` is 1, which means the block is idle. A `cmd_valid` raised while busy has no effect on the beats or the completion of the running command.
- R11: While `mem_req` is 1 and `mem_ready` is 0, the outputs `mem_req`, `mem_addr`, `mem_reg` and `mem_load` hold their values into the next cycle.
- R12: During and right after reset, `cmd_ready`=1, and `mem_req`, `done`, `base_wr`, `err_unimpl` and `err_end` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken this cycle if valid |
| cmd_base | input | 32 | Base register value |
| cmd_list | input | 16 | Register selection mask |
| cmd_mode | input | 2 | Addressing mode: bit1 = before, bit0 = increment |
| cmd_wb | input | 1 | Write the updated base back |
| cmd_dword | input | 1 | Element size 8 bytes (1) or 4 bytes (0) |
| cmd_load | input | 1 | Transfer direction, 1 = load |
| mem_req | output | 1 | Beat valid |
| mem_addr | output | 32 | Beat address |
| mem_reg | output | 4 | Register index of the beat |
| mem_load | output | 1 | Beat direction |
| mem_ready | input | 1 | Memory accepts the beat |
| done | output | 1 | One-cycle completion pulse |
| base_wr | output | 1 | Base writeback strobe |
| base_val | output | 32 | Writeback value |
| err_unimpl | output | 1 | Unsupported mode pulse |
| err_end | output | 1 | Last address differs from the planned end |

## Verification
The embedded properties check a set of rules on every cycle: beats hold steady while stalled, consecutive accepted beats step by exactly one element, no command is accepted while beats are pending, and writeback appears only right after a final handshake. The rejection pulse is likewise checked to never overlap a beat. The exact first address for each mode, the register order, the beat count and the writeback value depend on the command contents. Only the bench's scenarios can show these, by comparing every beat against a model queue under random stalls. That comparison covers all three supported modes, address wrap, both element sizes, empty lists and commands offered while busy.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  typedef enum logic [1:0] {
    PU_DEC_AFTER  = 2'b00,
    PU_INC_AFTER  = 2'b01,
    PU_DEC_BEFORE = 2'b10,
    PU_INC_BEFORE = 2'b11
  } pu_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/bxs_popcount.sv
module bxs_popcount #(
  parameter int LW = 16,
  localparam int CW = $clog2(LW + 1)
) (
  input  logic [LW-1:0] vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < LW; i++) cnt = cnt + CW'(vec[i]);
  end
endmodule

// File: rtl/bxs_lowest_bit.sv
module bxs_lowest_bit #(
  parameter int LW = 16,
  localparam int IW = $clog2(LW)
) (
  input  logic [LW-1:0] vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = LW - 1; i >= 0; i--) if (vec[i]) idx = IW'(i);
  end
endmodule

// File: rtl/bxs_addr_plan.sv
module bxs_addr_plan
  import bxs_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  input  logic          dword,
  input  pu_mode_e      mode,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] last_addr,
  output logic [AW-1:0] wb_addr
);
  logic [AW-1:0] elem;
  logic [AW-1:0] span;

  always_comb begin
    elem = dword ? AW'(8) : AW'(4);
    span = dword ? (AW'(count) << 3) : (AW'(count) << 2);
    unique case (mode)
      PU_INC_AFTER: begin
        first_addr = base;
        last_addr  = base + span - elem;
        wb_addr    = base + span;
      end
      PU_INC_BEFORE: begin
        first_addr = base + elem;
        last_addr  = base + span;
        wb_addr    = base + span;
      end
      PU_DEC_BEFORE: begin
        first_addr = base - span;
        last_addr  = base - elem;
        wb_addr    = base - span;
      end
      default: begin
        first_addr = base;
        last_addr  = base;
        wb_addr    = base;
      end
    endcase
  end
endmodule

// File: rtl/blk_xfer_addr_seq.sv
module blk_xfer_addr_seq
  import bxs_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  localparam int IW = $clog2(LW),
  localparam int CW = $clog2(LW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_base,
  input  logic [LW-1:0] cmd_list,
  input  logic [1:0]    cmd_mode,
  input  logic          cmd_wb,
  input  logic          cmd_dword,
  input  logic          cmd_load,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [IW-1:0] mem_reg,
  output logic          mem_load,
  input  logic          mem_ready,
  output logic          done,
  output logic          base_wr,
  output logic [AW-1:0] base_val,
  output logic          err_unimpl,
  output logic          err_end
);
  seq_state_e    state_q;
  logic [CW-1:0] n_sel;
  logic [AW-1:0] plan_first, plan_last, plan_wb;
  logic [AW-1:0] addr_q, end_q, wbval_q;
  logic [LW-1:0] rem_q, low_bit, rem_next;
  logic          wb_q, dword_q, load_q;
  logic          done_q, base_wr_q, err_unimpl_q, err_end_q;
  logic [AW-1:0] base_val_q;
  pu_mode_e      mode_in;

  assign mode_in = pu_mode_e'(cmd_mode);

  bxs_popcount #(.LW(LW)) u_count (.vec(cmd_list), .cnt(n_sel));

  bxs_addr_plan #(.AW(AW), .CW(CW)) u_plan (
    .base(cmd_base), .count(n_sel), .dword(cmd_dword), .mode(mode_in),
    .first_addr(plan_first), .last_addr(plan_last), .wb_addr(plan_wb)
  );

  bxs_lowest_bit #(.LW(LW)) u_pick (.vec(rem_q), .idx(mem_reg));

  assign low_bit  = rem_q & (~rem_q + LW'(1));
  assign rem_next = rem_q & ~low_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      end_q        <= '0;
      wbval_q      <= '0;
      rem_q        <= '0;
      wb_q         <= 1'b0;
      dword_q      <= 1'b0;
      load_q       <= 1'b0;
      done_q       <= 1'b0;
      base_wr_q    <= 1'b0;
      base_val_q   <= '0;
      err_unimpl_q <= 1'b0;
      err_end_q    <= 1'b0;
    end else begin
      done_q       <= 1'b0;
      base_wr_q    <= 1'b0;
      err_unimpl_q <= 1'b0;
      err_end_q    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (mode_in == PU_DEC_AFTER) begin
              err_unimpl_q <= 1'b1;
            end else if (n_sel == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_BUSY;
              addr_q  <= plan_first;
              end_q   <= plan_last;
              wbval_q <= plan_wb;
              rem_q   <= cmd_list;
              wb_q    <= cmd_wb;
              dword_q <= cmd_dword;
              load_q  <= cmd_load;
            end
          end
        end
        ST_BUSY: begin
          if (mem_ready) begin
            rem_q <= rem_next;
            if (rem_next == '0) begin
              state_q   <= ST_IDLE;
              done_q    <= 1'b1;
              base_wr_q <= wb_q;
              err_end_q <= (addr_q != end_q);
              if (wb_q) base_val_q <= wbval_q;
            end else begin
              addr_q <= addr_q + (dword_q ? AW'(8) : AW'(4));
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (state_q == ST_IDLE);
  assign mem_req    = (state_q == ST_BUSY);
  assign mem_addr   = addr_q;
  assign mem_load   = load_q;
  assign done       = done_q;
  assign base_wr    = base_wr_q;
  assign base_val   = base_val_q;
  assign err_unimpl = err_unimpl_q;
  assign err_end    = err_end_q;

  // R11: a stalled beat stays put
  a_r11_hold_beat: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_reg) && $stable(mem_load)));

  // R5: consecutive accepted beats step by one element
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req && mem_ready)) |->
      (mem_addr == $past(mem_addr) + (dword_q ? AW'(8) : AW'(4))));

  // R10: no command is taken while beats are pending
  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cmd_ready);

  // R6: writeback only right after a final handshake
  a_r6_wb_after_last: assert property (@(posedge clk) disable iff (rst)
    base_wr |-> (done && $past(mem_req && mem_ready)));

  // R8: rejection never coincides with a beat or a completion
  a_r8_reject_clean: assert property (@(posedge clk) disable iff (rst)
    err_unimpl |-> (!mem_req && !done && !base_wr && $past(cmd_valid && cmd_ready)));

  // R9: completion never overlaps a beat
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_req && cmd_ready));

  // R7: the planned end matches the last issued address
  a_r7_end_match: assert property (@(posedge clk) disable iff (rst)
    done |-> !err_end);
endmodule

// File: tb/tb_blk_xfer_addr_seq.sv
module tb_blk_xfer_addr_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_list = '0;
  logic [1:0]  cmd_mode = '0;
  logic        cmd_wb = 1'b0;
  logic        cmd_dword = 1'b0;
  logic        cmd_load = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [3:0]  mem_reg;
  logic        mem_load;
  logic        mem_ready = 1'b0;
  logic        done, base_wr, err_unimpl, err_end;
  logic [31:0] base_val;

  always #2.5 clk = ~clk;

  blk_xfer_addr_seq dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_list(cmd_list), .cmd_mode(cmd_mode),
    .cmd_wb(cmd_wb), .cmd_dword(cmd_dword), .cmd_load(cmd_load),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_reg(mem_reg),
    .mem_load(mem_load), .mem_ready(mem_ready), .done(done),
    .base_wr(base_wr), .base_val(base_val), .err_unimpl(err_unimpl),
    .err_end(err_end)
  );

  int          tests = 0;
  int          fails = 0;
  logic [31:0] q_addr[$];
  int          q_reg[$];
  logic [31:0] exp_wbv;
  bit          exp_wb;
  bit          exp_load;
  int          pending = 0;
  string       tag = "R2";
  bit          hold = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ready pattern, driven after the command driver in each cycle
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = hold ? 1'b0 : (lfsr[0] | lfsr[3]);
  end

  // reference comparison on every cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req) begin
        if (q_addr.size() == 0) begin
          check(1'b0, "R9", "beat with none expected", mem_addr, 32'h0);
        end else begin
          check(mem_addr == q_addr[0], tag, "beat address", mem_addr, q_addr[0]);
          check(int'(mem_reg) == q_reg[0], "R5", "beat register", {28'h0, mem_reg}, q_reg[0]);
          check(mem_load == exp_load, "R1", "beat direction", {31'h0, mem_load}, {31'h0, exp_load});
          if (mem_ready) begin
            void'(q_addr.pop_front());
            void'(q_reg.pop_front());
          end
        end
      end
      if (done) begin
        check(pending == 1, "R9", "done when not expected", 32'(pending), 32'd1);
        check(q_addr.size() == 0, "R1", "beats left at done", 32'(q_addr.size()), 32'h0);
        check(base_wr == exp_wb, "R6", "writeback strobe", {31'h0, base_wr}, {31'h0, exp_wb});
        if (exp_wb) check(base_val == exp_wbv, tag, "writeback value", base_val, exp_wbv);
        check(err_end == 1'b0, "R7", "end mismatch flag", {31'h0, err_end}, 32'h0);
        pending = 0;
      end
      if (err_unimpl) begin
        check(pending == 2, "R8", "unimplemented pulse", 32'(pending), 32'd2);
        pending = 0;
      end
      if (base_wr && !done) check(1'b0, "R6", "writeback outside done", 32'h1, 32'h0);
    end
  end

  task automatic issue(input logic [31:0] base, input logic [15:0] list,
                       input logic [1:0] mode, input bit wb, input bit dw,
                       input bit ld, input string req, input bit poke);
    int n = 0;
    logic [31:0] sz, span, first;
    do begin @(posedge clk); #1; end while (!cmd_ready);
    for (int i = 0; i < 16; i++) if (list[i]) n++;
    sz   = dw ? 32'd8 : 32'd4;
    span = sz * n;
    case (mode)
      2'b01: begin first = base;        exp_wbv = base + span; end
      2'b11: begin first = base + sz;   exp_wbv = base + span; end
      2'b10: begin first = base - span; exp_wbv = base - span; end
      default: begin first = base;      exp_wbv = base; end
    endcase
    tag = req;
    exp_load = ld;
    exp_wb = wb && (n != 0) && (mode != 2'b00);
    if (mode == 2'b00) begin
      pending = 2;
    end else begin
      pending = 1;
      for (int i = 0, k = 0; i < 16; i++) begin
        if (list[i]) begin
          q_addr.push_back(first + sz * k);
          q_reg.push_back(i);
          k++;
        end
      end
    end
    cmd_base = base; cmd_list = list; cmd_mode = mode;
    cmd_wb = wb; cmd_dword = dw; cmd_load = ld; cmd_valid = 1'b1;
    if (poke) hold = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    if (poke) begin
      // R10: a second command offered while busy must be ignored
      cmd_base = 32'h0000_0040; cmd_list = 16'h0003; cmd_mode = 2'b11;
      cmd_wb = 1'b1; cmd_load = ~ld; cmd_valid = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      cmd_valid = 1'b0;
      hold = 1'b0;
    end
    while (pending != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(!mem_req && !done && !err_unimpl, "R10", "quiet after command",
          {29'h0, mem_req, done, err_unimpl}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R12", "ready in reset", {31'h0, cmd_ready}, 32'h1);
    check({mem_req, done, base_wr, err_unimpl, err_end} == 5'b0, "R12", "outputs in reset",
          {27'h0, mem_req, done, base_wr, err_unimpl, err_end}, 32'h0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(cmd_ready && !mem_req && !done, "R12", "state after reset",
          {29'h0, cmd_ready, mem_req, done}, 32'h4);
    issue(32'h0000_1000, 16'h00A5, 2'b01, 1'b1, 1'b0, 1'b1, "R2", 1'b0);
    issue(32'h0000_3000, 16'h8001, 2'b11, 1'b1, 1'b1, 1'b0, "R3", 1'b0);
    issue(32'h0000_2000, 16'hFFFF, 2'b10, 1'b1, 1'b0, 1'b0, "R4", 1'b0);
    issue(32'h0000_2000, 16'h00F0, 2'b10, 1'b0, 1'b1, 1'b1, "R4", 1'b0);
    issue(32'hFFFF_FFF8, 16'h0007, 2'b01, 1'b1, 1'b0, 1'b1, "R5", 1'b0);
    issue(32'h0000_0100, 16'h00FF, 2'b00, 1'b1, 1'b0, 1'b1, "R8", 1'b0);
    issue(32'h0000_0200, 16'h0000, 2'b01, 1'b1, 1'b0, 1'b0, "R9", 1'b0);
    issue(32'h0000_5000, 16'h0F0F, 2'b11, 1'b1, 1'b0, 1'b1, "R10", 1'b1);
    issue(32'h0000_0010, 16'h4000, 2'b11, 1'b1, 1'b1, 1'b0, "R3", 1'b0);
    issue(32'h0000_0008, 16'h0300, 2'b10, 1'b1, 1'b1, 1'b1, "R4", 1'b0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule